// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss by reading a two-level page table held in memory and handing the resulting mapping to the translation buffer. A 32-bit virtual address is split into a 10-bit first-level index (bits 31:22), a 10-bit second-level index (bits 21:12) and a 12-bit page offset (bits 11:0). The offset is not involved in the walk. The first-level table starts at the page-aligned address held in the root pointer register. Each first-level entry points to a page-aligned second-level table. Each second-level entry supplies the physical page number.

A table entry is 32 bits. Bit 0 means present. Bits 31:12 carry either the next table's page-aligned base or the physical page number. Bits 11:1 are ignored. An entry's address is its table base plus four times its index. A missing entry at either level ends the walk with a fault pulse that names the level, and no fill is produced. When the walker is disabled, a presented miss is answered in the same cycle with a request for a software refill, and no memory is touched.

Only one walk runs at a time. The memory port has a single outstanding read: a one-cycle request pulse, an address held until a data-valid pulse, and any number of wait cycles in between.

Top module: `pt_walker`

## Requirements
- R1: The first read goes to `{root_ptr[31:12], vaddr[31:22], 2'b00}`, so bits 11:0 of the root pointer are ignored. Every read address is word aligned.
- R2: After a present first-level entry, the second read goes to `{entry1[31:12], vaddr[21:12], 2'b00}`. Entry bits 11:1 have no effect.
- R3: When both entries are present, `fill_valid` pulses with `fill_vpn = vaddr[31:12]` and `fill_ppn = entry2[31:12]`. `fill_valid` and `fault` are never high together.
- R4: A first-level entry with bit 0 clear raises `fault` with `fault_level = 0`. No second read is issued and no fill is produced.
- R5: A second-level entry with bit 0 clear raises `fault` with `fault_level = 1` and produces no fill.
- R6: Each read is a single-cycle `mem_req` pulse. `mem_addr` stays stable until `mem_rvalid` arrives, however many cycles that takes.
- R7: `miss_ready` is high only while the walker is idle. A miss presented while a walk is in progress has no effect on that walk.
- R8: With `walk_en` low, an idle walker that sees `miss_valid` drives `sw_refill` high in the same cycle, issues no read and stays idle. `walk_en` is sampled only when a miss is accepted.
- R9: `fill_valid` and `fault` last one cycle, and `miss_ready` is high again in the following cycle.
- R10: A synchronous `rst` returns the walker to idle and discards any walk in progress. A `mem_rvalid` seen while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| walk_en | input | 1 | Hardware walk enable |
| root_ptr | input | 32 | First-level table base (bits 31:12 used) |
| miss_valid | input | 1 | Miss request present |
| miss_ready | output | 1 | Walker idle, miss accepted |
| miss_vaddr | input | 32 | Virtual address of the miss |
| sw_refill | output | 1 | Miss refused, software must refill |
| mem_req | output | 1 | Read request pulse |
| mem_addr | output | 32 | Read address |
| mem_rvalid | input | 1 | Read data valid pulse |
| mem_rdata | input | 32 | Read data (table entry) |
| fill_valid | output | 1 | Translation fill pulse |
| fill_vpn | output | 20 | Virtual page number of the fill |
| fill_ppn | output | 20 | Physical page number of the fill |
| fault | output | 1 | Missing entry pulse |
| fault_level | output | 1 | 0: first level, 1: second level |

## Verification
The bench sets the entry's spare bits (11:1) and the low bits of the root pointer. A design that forms addresses from those bits sends reads to the wrong words. It also runs walks with both zero-cycle and multi-cycle memory latency. A walker that re-issues requests or lets the address drift during waits, or one that takes the data one cycle early, shows up in the read stream. Missing entries are placed at each level: a walker that goes on past a missing first-level entry makes a second read, and one that reports the wrong level shows up in `fault_level`. The bench also presents misses while busy and while disabled, resets in the middle of a walk, and sends stray data-valid pulses when idle. A walker that lets any of these leak into its state starts or corrupts a walk.

// File: rtl/pt_walker.sv
module pt_walker (
  input  logic        clk,
  input  logic        rst,
  input  logic        walk_en,
  input  logic [31:0] root_ptr,
  input  logic        miss_valid,
  output logic        miss_ready,
  input  logic [31:0] miss_vaddr,
  output logic        sw_refill,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  output logic        fill_valid,
  output logic [19:0] fill_vpn,
  output logic [19:0] fill_ppn,
  output logic        fault,
  output logic        fault_level
);
  localparam int OFF_W = 12;
  localparam int IDX_W = 10;
  localparam int PN_W  = 32 - OFF_W;

  typedef enum logic [2:0] {IDLE, L1_REQ, L1_WAIT, L2_REQ, L2_WAIT, FILL, FAULT} st_t;
  st_t st, st_nx;

  logic [PN_W-1:0] vpn_q, ppn_q;
  logic [31:0]     addr_q;
  logic            lvl_q;

  wire take    = (st == IDLE) && miss_valid && walk_en;
  wire present = mem_rdata[0];
  wire unused_bits = ^{root_ptr[OFF_W-1:0], miss_vaddr[OFF_W-1:0], mem_rdata[OFF_W-1:1]};

  always_comb begin
    st_nx = st;
    case (st)
      IDLE:    if (take) st_nx = L1_REQ;
      L1_REQ:  st_nx = L1_WAIT;
      L1_WAIT: if (mem_rvalid) st_nx = present ? L2_REQ : FAULT;
      L2_REQ:  st_nx = L2_WAIT;
      L2_WAIT: if (mem_rvalid) st_nx = present ? FILL : FAULT;
      default: st_nx = IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= IDLE;
      vpn_q  <= '0;
      ppn_q  <= '0;
      addr_q <= '0;
      lvl_q  <= 1'b0;
    end else begin
      st <= st_nx;
      if (take) begin
        vpn_q  <= miss_vaddr[31:OFF_W];
        addr_q <= {root_ptr[31:OFF_W], miss_vaddr[31:32-IDX_W], 2'b00};
      end
      if (st == L1_WAIT && mem_rvalid) begin
        lvl_q  <= 1'b0;
        addr_q <= {mem_rdata[31:OFF_W], vpn_q[IDX_W-1:0], 2'b00};
      end
      if (st == L2_WAIT && mem_rvalid) begin
        lvl_q <= 1'b1;
        ppn_q <= mem_rdata[31:OFF_W];
      end
    end
  end

  assign miss_ready  = (st == IDLE);
  assign sw_refill   = (st == IDLE) && miss_valid && !walk_en;
  assign mem_req     = (st == L1_REQ) || (st == L2_REQ);
  assign mem_addr    = addr_q;
  assign fill_valid  = (st == FILL);
  assign fill_vpn    = vpn_q;
  assign fill_ppn    = ppn_q;
  assign fault       = (st == FAULT);
  assign fault_level = lvl_q;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
  input logic        clk,
  input logic        rst,
  input logic        miss_ready,
  input logic        sw_refill,
  input logic        mem_req,
  input logic [31:0] mem_addr,
  input logic        fill_valid,
  input logic        fault
);
  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (rst) mem_req |-> mem_addr[1:0] == 2'b00); // R1
  AST_FILL_FAULT_EXCL: assert property (@(posedge clk) disable iff (rst) !(fill_valid && fault)); // R3
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst) mem_req |=> (!mem_req && $stable(mem_addr))); // R6
  AST_REQ_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst) mem_req |-> !miss_ready); // R7
  AST_REFILL_NO_READ: assert property (@(posedge clk) disable iff (rst) sw_refill |=> (miss_ready && !mem_req)); // R8
  AST_FILL_PULSE: assert property (@(posedge clk) disable iff (rst) fill_valid |=> (!fill_valid && miss_ready)); // R9
  AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (rst) fault |=> (!fault && miss_ready)); // R9
  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (miss_ready && !mem_req && !fill_valid && !fault)); // R10
endmodule

bind pt_walker pt_walker_chk u_chk (
  .clk(clk), .rst(rst), .miss_ready(miss_ready), .sw_refill(sw_refill),
  .mem_req(mem_req), .mem_addr(mem_addr), .fill_valid(fill_valid), .fault(fault)
);

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;
  logic clk = 1'b0, rst = 1'b1, walk_en = 1'b1, miss_valid = 1'b0, mem_rvalid = 1'b0;
  logic [31:0] root_ptr = '0, miss_vaddr = '0, mem_rdata = '0, mem_addr;
  logic miss_ready, sw_refill, mem_req, fill_valid, fault, fault_level;
  logic [19:0] fill_vpn, fill_ppn;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  pt_walker u_pt_walker (.*);

  localparam int NV = 6;
  // kind: 0 = fill, 1 = first-level fault, 2 = second-level fault
  localparam logic [31:0] V_ROOT [NV] = '{32'h0004_0000, 32'h0008_0FFF, 32'h0001_0000, 32'h0002_0000, 32'hFFFF_F000, 32'h1234_5000};
  localparam logic [31:0] V_VA   [NV] = '{32'h0040_3123, 32'hFFFF_FFFF, 32'h8000_0000, 32'h0000_1000, 32'h7FC0_0ABC, 32'h3FF0_0000};
  localparam logic [31:0] V_E1   [NV] = '{32'h0012_3001, 32'h1000_0FFF, 32'h0ABC_DFFE, 32'h0030_0001, 32'h0000_0001, 32'hFFFF_F001};
  localparam logic [31:0] V_E2   [NV] = '{32'hABCD_E001, 32'h7654_3FFF, 32'h1111_1001, 32'h0040_0FFE, 32'h0000_1001, 32'h0000_0000};
  localparam int          V_LAT  [NV] = '{0, 3, 2, 1, 7, 0};
  localparam int          V_KIND [NV] = '{0, 0, 1, 2, 0, 2};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic walk(input logic [31:0] root, input logic [31:0] va, input logic [31:0] e1,
                      input logic [31:0] e2, input int lat, input int kind);
    logic [31:0] a1, a2;
    a1 = {root[31:12], va[31:22], 2'b00};
    a2 = {e1[31:12], va[21:12], 2'b00};
    @(negedge clk);
    root_ptr = root; miss_vaddr = va; miss_valid = 1'b1;
    chk(miss_ready, "R7 ready when idle", {31'b0, miss_ready}, 32'd1);
    @(negedge clk);
    miss_vaddr = ~va; root_ptr = ~root;
    chk(mem_req && mem_addr == a1, "R1 first read address", mem_addr, a1);
    @(negedge clk);
    chk(!mem_req && !miss_ready, "R6/R7 single request, busy", {30'b0, mem_req, miss_ready}, 32'd0);
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      chk(!mem_req && mem_addr == a1, "R6 address held in wait", mem_addr, a1);
    end
    miss_valid = 1'b0; mem_rvalid = 1'b1; mem_rdata = e1;
    @(negedge clk);
    mem_rvalid = 1'b0; mem_rdata = 32'hDEAD_BEEF;
    if (kind == 1) begin
      chk(fault && !fault_level && !fill_valid && !mem_req, "R4 first-level fault",
          {29'b0, fault, fault_level, fill_valid}, 32'd4);
    end else begin
      chk(mem_req && mem_addr == a2, "R2 second read address", mem_addr, a2);
      @(negedge clk);
      for (int i = 0; i < lat; i++) begin
        @(negedge clk);
        chk(!mem_req && mem_addr == a2, "R6 address held in wait", mem_addr, a2);
      end
      mem_rvalid = 1'b1; mem_rdata = e2;
      @(negedge clk);
      mem_rvalid = 1'b0; mem_rdata = 32'hDEAD_BEEF;
      if (kind == 0) begin
        chk(fill_valid && !fault && fill_vpn == va[31:12], "R3 fill vpn", {12'b0, fill_vpn}, {12'b0, va[31:12]});
        chk(fill_ppn == e2[31:12], "R3 fill ppn", {12'b0, fill_ppn}, {12'b0, e2[31:12]});
      end else begin
        chk(fault && fault_level && !fill_valid, "R5 second-level fault",
            {29'b0, fault, fault_level, fill_valid}, 32'd6);
      end
    end
    @(negedge clk);
    chk(miss_ready && !fill_valid && !fault, "R9 one-cycle result then ready",
        {29'b0, miss_ready, fill_valid, fault}, 32'd4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(miss_ready && !mem_req && !fill_valid && !fault && !sw_refill, "R10 reset state",
        {27'b0, miss_ready, mem_req, fill_valid, fault, sw_refill}, 32'd16);

    for (int v = 0; v < NV; v++)
      walk(V_ROOT[v], V_VA[v], V_E1[v], V_E2[v], V_LAT[v], V_KIND[v]);

    // R8: disabled walker refuses the miss at once
    @(negedge clk);
    walk_en = 1'b0;
    chk(!sw_refill, "R8 no refill without a miss", {31'b0, sw_refill}, 32'd0);
    miss_valid = 1'b1; miss_vaddr = 32'h1234_5678; root_ptr = 32'h0000_0000;
    #0.1;
    chk(sw_refill && miss_ready, "R8 refill same cycle", {30'b0, sw_refill, miss_ready}, 32'd3);
    @(negedge clk);
    miss_valid = 1'b0;
    chk(!mem_req && miss_ready, "R8 no read when disabled", {30'b0, mem_req, miss_ready}, 32'd1);
    @(negedge clk);
    chk(!mem_req && !fill_valid && !fault, "R8 stays idle", {29'b0, mem_req, fill_valid, fault}, 32'd0);

    // R8: enable dropped mid-walk does not stop an accepted walk
    walk_en = 1'b1;
    miss_valid = 1'b1; miss_vaddr = 32'h0080_2000; root_ptr = 32'h0005_0000;
    @(negedge clk);
    miss_valid = 1'b0; walk_en = 1'b0;
    chk(mem_req && mem_addr == 32'h0005_0008, "R8 walk continues after disable", mem_addr, 32'h0005_0008);
    @(negedge clk);
    mem_rvalid = 1'b1; mem_rdata = 32'h0007_0001;
    @(negedge clk);
    mem_rvalid = 1'b0;
    chk(mem_req && mem_addr == 32'h0007_0008, "R2 second read after disable", mem_addr, 32'h0007_0008);
    @(negedge clk);
    mem_rvalid = 1'b1; mem_rdata = 32'h000A_B001;
    @(negedge clk);
    mem_rvalid = 1'b0;
    chk(fill_valid && fill_ppn == 20'h000AB, "R3 fill after disable", {12'b0, fill_ppn}, 32'h000AB);
    @(negedge clk);
    walk_en = 1'b1;

    // R10: reset mid-walk, stray data-valid while idle
    miss_valid = 1'b1; miss_vaddr = 32'h0040_0000; root_ptr = 32'h0006_0000;
    @(negedge clk);
    miss_valid = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(miss_ready && !mem_req, "R10 reset discards walk", {30'b0, miss_ready, mem_req}, 32'd2);
    mem_rvalid = 1'b1; mem_rdata = 32'hFFFF_F001;
    @(negedge clk);
    mem_rvalid = 1'b0;
    chk(miss_ready && !mem_req && !fill_valid && !fault, "R10 stray data ignored",
        {28'b0, miss_ready, mem_req, fill_valid, fault}, 32'd8);
    @(negedge clk);
    chk(!fill_valid && !fault && miss_ready, "R10 still idle", {29'b0, miss_ready, fill_valid, fault}, 32'd4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule